// File: doc/BRIEF.md
# Supervisory Reset Generator with Watchdog

This block drives the reset lines of a microcontroller. It provides an active-low reset and an active-high reset, and the two are always complements of each other. Three sources can start a reset. The first is a supply-undervoltage flag from an analog comparator. The second is an active-low push-button input. The third is a watchdog that times out when software stops toggling its service input. Reset is held for as long as a level source (undervoltage or push-button) is present. After every reset ends, reset is held for a further recovery time.

All timing is counted in millisecond ticks, which arrive as one-cycle pulses on `ms_tick_i`. The recovery time and the watchdog timeout are parameters (`REC_MS`, `WD_MS`), so a short configuration can be tested quickly. The push-button and watchdog inputs are asynchronous, and each passes through a two-flop synchronizer. The undervoltage flag is taken to be synchronous to `clk_i` already.

A watchdog input that never changes produces a repeating train of resets. The period of that train is `WD_MS + REC_MS` ticks. The watchdog can be switched off with the float flag.

Top module: `supv_reset`

## Requirements
- R1: After `rst_ni` is released, reset is asserted (`rst_o`=1) and stays asserted for exactly `REC_MS` ticks. It is still asserted after `REC_MS-1` ticks and is deasserted after `REC_MS` ticks.
- R2: While `uv_i`=1, reset is held and the recovery count stays at zero. Counting of `REC_MS` ticks starts only once `uv_i` returns to 0. If `uv_i` reappears during recovery, the count restarts from zero.
- R3: While `mr_ni`=0, reset is held for any number of ticks. Once `mr_ni` returns to 1, reset releases after exactly `REC_MS` ticks.
- R4: If the synchronized watchdog input shows no edge for `WD_MS` ticks, a reset is triggered. It then lasts `REC_MS` ticks.
- R5: A rising edge or a falling edge on `wdi_i` clears the watchdog count. After an edge, a further `WD_MS` ticks with no edge are needed before a timeout.
- R6: The watchdog count is held at zero while reset is asserted. With `wdi_i` static, reset deasserts for `WD_MS` ticks and then asserts for `REC_MS` ticks, and this repeats.
- R7: While `wd_float_i`=1, the watchdog never times out, whatever the number of ticks.
- R8: `rst_no_o` is always the complement of `rst_o`.
- R9: If a watchdog-input edge is detected in the same cycle as the tick that would end the timeout, the edge wins. No reset occurs, and a full `WD_MS` ticks are needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| uv_i | input | 1 | Supply undervoltage flag, 1 = below threshold |
| mr_ni | input | 1 | Manual push-button reset, active low, asynchronous |
| wdi_i | input | 1 | Watchdog service input, asynchronous |
| wd_float_i | input | 1 | 1 = watchdog input floated, watchdog disabled |
| rst_no | output | 1 | Active-low reset output |
| rst_o | output | 1 | Active-high reset output |

## Verification
Two events can land in the same clock cycle: a detected edge on the watchdog input, and the millisecond tick that would take the watchdog count to its limit. The bench waits until `WD_MS-1` ticks have passed with no edge. It then toggles `wdi_i` so that the synchronized edge reaches the detector two cycles later. The tick is driven so that it is sampled in that same cycle. The expected outcome is that no reset follows, and that a further `WD_MS-1` quiet ticks still leave reset deasserted. A timeout is expected only on the `WD_MS`-th tick.

// File: rtl/supv_pkg.sv
package supv_pkg;
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
  import supv_pkg::*;
#(
  parameter int WD_MS = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wdi_s_i,
  input  logic float_i,
  input  logic rst_act_i,
  output logic to_o
);
  localparam int W = cnt_w(WD_MS);
  localparam logic [W-1:0] LAST = W'(WD_MS - 1);

  logic         wdi_q;
  logic         edge_d;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdi_q <= 1'b0;
    else         wdi_q <= wdi_s_i;
  end

  assign edge_d = wdi_s_i ^ wdi_q;

  // clear conditions take priority over the expiring tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_o  <= 1'b0;
    end else if (rst_act_i || float_i || edge_d) begin
      cnt_q <= '0;
      to_o  <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        to_o  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        to_o  <= 1'b0;
      end
    end else begin
      to_o <= 1'b0;
    end
  end

  p_clr_in_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_act_i |=> (cnt_q == '0 && !to_o));
  p_float_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_i |=> !to_o);
  p_edge_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_d && tick_i) |=> (cnt_q == '0 && !to_o));
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
  import supv_pkg::*;
#(
  parameter int REC_MS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  input  logic trig_i,
  output logic act_o
);
  localparam int W = cnt_w(REC_MS);
  localparam logic [W-1:0] LAST = W'(REC_MS - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b1;
      cnt_q <= '0;
    end else if (hold_i || trig_i) begin
      act_o <= 1'b1;
      cnt_q <= '0;
    end else if (act_o && tick_i) begin
      if (cnt_q == LAST) begin
        act_o <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> act_o);
  p_release_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_o) |-> ($past(tick_i) && !$past(hold_i) && !$past(trig_i)));
endmodule

// File: rtl/supv_reset.sv
module supv_reset #(
  parameter int REC_MS   = 200,
  parameter int WD_MS    = 1600,
  parameter int SYNC_STG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ms_tick_i,
  input  logic uv_i,
  input  logic mr_ni,
  input  logic wdi_i,
  input  logic wd_float_i,
  output logic rst_no,
  output logic rst_o
);
  logic mr_s, wdi_s, wd_to, act;

  supv_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_mr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mr_ni), .q_o(mr_s));

  supv_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_wdi_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wdi_i), .q_o(wdi_s));

  supv_wdog #(.WD_MS(WD_MS)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(ms_tick_i), .wdi_s_i(wdi_s),
    .float_i(wd_float_i), .rst_act_i(act), .to_o(wd_to));

  supv_stretch #(.REC_MS(REC_MS)) u_stretch (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(ms_tick_i),
    .hold_i(uv_i | ~mr_s), .trig_i(wd_to), .act_o(act));

  assign rst_o  = act;
  assign rst_no = ~act;

  p_to_asserts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_to |=> rst_o);
endmodule

// File: tb/sim_supv_reset.sv
module sim_supv_reset;
  localparam int REC = 5;
  localparam int WD  = 8;
  localparam int NV  = 21;

  logic clk = 1'b0;
  logic rst_n, tick, uv, mr_n, wdi, fl;
  logic rst_no, rst_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  supv_reset #(.REC_MS(REC), .WD_MS(WD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(tick), .uv_i(uv), .mr_ni(mr_n),
    .wdi_i(wdi), .wd_float_i(fl), .rst_no(rst_no), .rst_o(rst_o));

  // {uv, mr_n, wdi, float, ticks[7:0], expected rst_o}
  function automatic logic [12:0] v(input bit u, m, w, f, input int n, input bit e);
    return {u, m, w, f, 8'(n), e};
  endfunction

  localparam logic [12:0] VEC [NV] = '{
    v(0,1,0,0, 4,1), v(0,1,0,0, 1,0),                    // R1 power-on recovery
    v(0,1,1,0, 7,0), v(0,1,0,0, 7,0),                    // R5 edges clear
    v(0,1,0,0, 1,1), v(0,1,0,0, 4,1), v(0,1,0,0, 1,0),   // R4 timeout + recovery
    v(0,0,0,0,20,1), v(0,1,0,0, 4,1), v(0,1,0,0, 1,0),   // R3 manual
    v(1,1,0,0, 3,1), v(0,1,0,0, 3,1), v(1,1,0,0, 1,1),   // R2 undervoltage restart
    v(0,1,0,0, 4,1), v(0,1,0,0, 1,0),
    v(0,1,0,1,30,0),                                     // R7 float
    v(0,1,0,0, 7,0), v(0,1,0,0, 1,1), v(0,1,0,0, 5,0),   // R6 stuck train
    v(0,1,0,0, 7,0), v(0,1,0,0, 1,1)
  };

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (rst_o !== exp) begin
      n_bad++;
      $display("FAIL %s rst_o act=%b exp=%b t=%0t", req, rst_o, exp, $time);
    end
    n_chk++;
    if (rst_no !== ~rst_o) begin
      n_bad++;
      $display("FAIL R8 rst_no act=%b exp=%b t=%0t", rst_no, ~rst_o, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      idle(2);
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; uv = 1'b0; mr_n = 1'b1; wdi = 1'b0; fl = 1'b0;
    idle(3);
    check(1'b1, "R1 reset state");
    rst_n = 1'b1;
    idle(1);

    for (int k = 0; k < NV; k++) begin
      uv   = VEC[k][12];
      mr_n = VEC[k][11];
      wdi  = VEC[k][10];
      fl   = VEC[k][9];
      idle(3);
      ticks(int'(VEC[k][8:1]));
      check(VEC[k][0], $sformatf("R1-R7 vector %0d", k));
    end

    // release the train reset, then R9: edge lands with the expiring tick
    ticks(REC);
    check(1'b0, "R6 released");
    ticks(WD - 1);
    check(1'b0, "R9 before coincidence");
    wdi = ~wdi;
    idle(2);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    idle(3);
    check(1'b0, "R9 edge beats expiring tick");
    ticks(WD - 1);
    check(1'b0, "R9 full window restarted");
    ticks(1);
    check(1'b1, "R9 timeout after full window");

    // R6: edges during reset do not shorten or extend it
    wdi = ~wdi;
    idle(3);
    ticks(REC - 1);
    check(1'b1, "R6 edge during reset");
    ticks(1);
    check(1'b0, "R6 release");

    // R3: manual press in mid-recovery restarts recovery
    mr_n = 1'b0; idle(4); mr_n = 1'b1; idle(3);
    ticks(2);
    mr_n = 1'b0; idle(4); mr_n = 1'b1; idle(3);
    ticks(REC - 1);
    check(1'b1, "R3 restart");
    ticks(1);
    check(1'b0, "R3 release");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule